// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block holds the digital control for an 8-bit successive-approximation converter that serves six multiplexed analog inputs. A one-cycle start request, together with a channel number and two clock settings, begins a conversion. The block then steers the input multiplexer and runs a fixed sampling window. After that it tests the result one bit at a time, from the most significant bit down, by driving a trial code to an external DAC and reading back a comparator bit.

The converter clock is not a separate clock. It is a tick enable that the block derives from the system clock. A select bit and a two-bit prescaler field set the divide ratio. Each conversion lasts exactly 160 ticks: a 12-tick sampling window, eight trial slots of 18 ticks each, and a 4-tick settling tail. When the conversion ends, the result register loads, a sticky done flag sets and an interrupt pulse fires. The comparator, DAC and sample-hold are outside the block.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, irq, sample, the result and the DAC code are all 0.
- R2: An accepted conversion keeps busy high for exactly 160·N system clocks. N is 2, 4 or 16 for clock select 0 with prescaler 00, 01 or 11. N is 1, 2 or 8 for clock select 1 with the same prescaler values.
- R3: Prescaler value 10 gives the same N as prescaler value 00, for either clock select.
- R4: The sample output is high for the first 12·N clocks of a conversion. During that time the DAC code is 0. The channel select output holds the channel accepted at start.
- R5: The result equals the largest 8-bit code whose trial produced comparator 1. Comparator 1 means the input is at or above the DAC code. Each bit is decided at the end of its trial slot.
- R6: At completion, busy falls and, on the same edge, the result loads, done sets and irq is high for exactly one clock. Done stays set until the next accepted start clears it.
- R7: A start request while busy is ignored. The channel, the duration and the result of the running conversion are unaffected.
- R8: A start request with a channel number above 5 is ignored. Busy stays low and the result and done stay unchanged.
- R9: The clock settings are captured at start. Changing them during a conversion does not change its duration.
- R10: The first trial code after the sampling window is 0x80. Trials proceed from bit 7 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, one clock |
| chan_i | input | 3 | Channel number for the request (0 to 5) |
| cks_i | input | 1 | Converter clock select bit |
| pre_i | input | 2 | CPU prescaler field |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the DAC code |
| chan_sel_o | output | 3 | Input multiplexer select |
| sample_o | output | 1 | Sampling window active |
| dac_code_o | output | 8 | Trial code to the DAC |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 8 | Last conversion result |
| done_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | One-clock completion pulse |

## Verification
Some properties are checked on every cycle. Ticks occur only while busy. Busy can fall only together with irq and done. Irq never lasts two cycles. The result changes only at completion. The captured channel and divide ratio stay fixed while busy, the DAC code is zero while sampling, and the trial bit index steps down by one per slot. Other behaviour needs a whole conversion to show and is left to the bench scenarios. These are the exact duration for every clock-select and prescaler pair, the width of the sampling window, the first trial code, and the final code against a behavioural comparator for several input levels. They also include the effect of a start or a settings change in the middle of a conversion.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRIAL  = 2'd2,
    PH_TAIL   = 2'd3
  } sar_phase_e;

  // System clocks per converter tick. Prescaler 2'b10 falls back to 2'b00.
  function automatic int unsigned fadc_div(input logic cks, input logic [1:0] pre);
    int unsigned base;
    case (pre)
      2'b01:   base = 4;
      2'b11:   base = 16;
      default: base = 2;
    endcase
    return cks ? base / 2 : base;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;

  assign tick = run && (cnt == (div - 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end

  // R2: the prescale counter never runs past the captured ratio
  a_r2_cnt_below_div: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < div));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS = 8,
  parameter int TOTAL_T  = 160,
  parameter int SAMPLE_T = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_acc,
  input  logic                        tick,
  output logic                        busy,
  output logic                        sample,
  output logic                        trial,
  output logic                        slot_end,
  output logic                        fin,
  output logic [$clog2(RES_BITS)-1:0] bit_idx
);
  localparam int SLOT_T = (TOTAL_T - SAMPLE_T) / RES_BITS;
  localparam int TAIL_T = TOTAL_T - SAMPLE_T - SLOT_T * RES_BITS;
  localparam bit HAS_TAIL = (TAIL_T > 0);
  localparam int PH_W = $clog2(max3(SAMPLE_T, SLOT_T, TAIL_T) + 1);
  localparam int BIT_W = $clog2(RES_BITS);
  localparam logic [PH_W-1:0] SAMPLE_LAST = PH_W'(SAMPLE_T - 1);
  localparam logic [PH_W-1:0] SLOT_LAST   = PH_W'(SLOT_T - 1);
  localparam logic [PH_W-1:0] TAIL_LAST   = PH_W'((TAIL_T == 0) ? 0 : TAIL_T - 1);
  localparam logic [BIT_W-1:0] BIT_TOP    = BIT_W'(RES_BITS - 1);

  sar_phase_e      st;
  logic [PH_W-1:0] ph;

  assign busy     = (st != PH_IDLE);
  assign sample   = (st == PH_SAMPLE);
  assign trial    = (st == PH_TRIAL);
  assign slot_end = tick && trial && (ph == SLOT_LAST);
  assign fin      = tick && (((st == PH_TAIL) && (ph == TAIL_LAST)) ||
                    (!HAS_TAIL && slot_end && (bit_idx == '0)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= PH_IDLE;
      ph      <= '0;
      bit_idx <= '0;
    end else begin
      case (st)
        PH_IDLE: if (start_acc) begin
          st      <= PH_SAMPLE;
          ph      <= '0;
          bit_idx <= BIT_TOP;
        end
        PH_SAMPLE: if (tick) begin
          if (ph == SAMPLE_LAST) begin
            st <= PH_TRIAL;
            ph <= '0;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        PH_TRIAL: if (tick) begin
          if (ph == SLOT_LAST) begin
            ph <= '0;
            if (bit_idx == '0) st <= HAS_TAIL ? PH_TAIL : PH_IDLE;
            else bit_idx <= bit_idx - 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        PH_TAIL: if (tick) begin
          if (ph == TAIL_LAST) begin
            st <= PH_IDLE;
            ph <= '0;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  a_r5_bit_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && (bit_idx != '0)) |=> (bit_idx == $past(bit_idx) - 1'b1));
  a_r10_trial_starts_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && tick && (ph == SAMPLE_LAST)) |=> (trial && (bit_idx == BIT_TOP)));
  a_r2_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    trial |-> (ph <= SLOT_LAST));
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES_BITS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_acc,
  input  logic                        trial,
  input  logic                        slot_end,
  input  logic                        fin,
  input  logic                        cmp_i,
  input  logic [$clog2(RES_BITS)-1:0] bit_idx,
  output logic [RES_BITS-1:0]         dac_code,
  output logic [RES_BITS-1:0]         result,
  output logic                        done,
  output logic                        irq
);
  logic [RES_BITS-1:0] acc, mask, next_acc;

  assign mask     = RES_BITS'(1) << bit_idx;
  assign next_acc = (slot_end && cmp_i) ? (acc | mask) : acc;
  assign dac_code = trial ? (acc | mask) : acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      result <= '0;
      done   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      acc <= start_acc ? '0 : next_acc;
      if (fin) begin
        result <= next_acc;
        done   <= 1'b1;
      end else if (start_acc) begin
        done <= 1'b0;
      end
      irq <= fin;
    end
  end

  a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r6_result_only_at_fin: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(result));
  a_r5_acc_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (trial && !start_acc) |=> ((acc & $past(acc)) == $past(acc)));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS = 8,
  parameter int NUM_CH   = 6,
  parameter int TOTAL_T  = 160,
  parameter int SAMPLE_T = 12,
  parameter int DIV_MAX  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [$clog2(NUM_CH)-1:0] chan_i,
  input  logic                      cks_i,
  input  logic [1:0]                pre_i,
  input  logic                      cmp_i,
  output logic [$clog2(NUM_CH)-1:0] chan_sel_o,
  output logic                      sample_o,
  output logic [RES_BITS-1:0]       dac_code_o,
  output logic                      busy_o,
  output logic [RES_BITS-1:0]       result_o,
  output logic                      done_o,
  output logic                      irq_o
);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int DW    = $clog2(DIV_MAX + 1);
  localparam int BIT_W = $clog2(RES_BITS);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic             start_acc, tick, trial, slot_end, fin;
  logic [DW-1:0]    div_q;
  logic [CH_W-1:0]  chan_q;
  logic [BIT_W-1:0] bit_idx;

  assign start_acc  = start_i && !busy_o && (chan_i <= LAST_CH);
  assign chan_sel_o = chan_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= DW'(1);
      chan_q <= '0;
    end else if (start_acc) begin
      div_q  <= DW'(fadc_div(cks_i, pre_i));
      chan_q <= chan_i;
    end
  end

  sar_tick_gen #(.DW(DW)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .run(busy_o), .div(div_q), .tick(tick)
  );

  sar_seq #(.RES_BITS(RES_BITS), .TOTAL_T(TOTAL_T), .SAMPLE_T(SAMPLE_T)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .tick(tick), .busy(busy_o),
    .sample(sample_o), .trial(trial), .slot_end(slot_end), .fin(fin), .bit_idx(bit_idx)
  );

  sar_approx #(.RES_BITS(RES_BITS)) u_approx (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .trial(trial), .slot_end(slot_end),
    .fin(fin), .cmp_i(cmp_i), .bit_idx(bit_idx), .dac_code(dac_code_o),
    .result(result_o), .done(done_o), .irq(irq_o)
  );

  a_r2_tick_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> busy_o);
  a_r6_busy_falls_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (irq_o && done_o));
  a_r7_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(chan_q));
  a_r9_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(div_q));
  a_r4_dac_zero_sampling: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> (dac_code_o == '0));
endmodule

// File: tb/sar_adc_ctrl_tb.sv
`timescale 1ns/1ps
module sar_adc_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] chan = '0;
  logic       cks = 1'b0;
  logic [1:0] pre = '0;
  logic       cmp;
  logic [2:0] chan_sel;
  logic       sample, busy, done, irq;
  logic [7:0] dac, result;

  int unsigned vin [6] = '{8'h00, 8'hFF, 8'h5A, 8'h80, 8'h7F, 8'h33};
  int n_chk = 0;
  int n_fail = 0;
  int cyc_total = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  // behavioural comparator: 1 when the selected input is at or above the DAC code
  assign cmp = (chan_sel < 3'd6) ? (vin[chan_sel] >= 32'(dac)) : 1'b0;

  sar_adc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .chan_i(chan), .cks_i(cks), .pre_i(pre),
    .cmp_i(cmp), .chan_sel_o(chan_sel), .sample_o(sample), .dac_code_o(dac),
    .busy_o(busy), .result_o(result), .done_o(done), .irq_o(irq)
  );

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc_total);
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // independent restatement of the ratio table
  function automatic int ratio(input bit c, input int p);
    int t0 [4] = '{2, 4, 2, 16};
    int t1 [4] = '{1, 2, 1, 8};
    return c ? t1[p] : t0[p];
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check(busy == 0 && done == 0 && irq == 0 && sample == 0, "R1 flags in reset",
          {busy, done, irq, sample}, 0);
    check(result == 0 && dac == 0, "R1 data in reset", result, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && irq == 0 && result == 0, "R1 idle after reset",
          {busy, done, irq}, 0);
  endtask

  // poke_mode: 0 none, 1 start on another channel (R7), 2 change clock settings (R9)
  task automatic run_conv(input string tag, input int ch, input bit c, input int p,
                          input int poke_at, input int poke_mode);
    int n, busy_n, samp_n, samp_bad, first_trial, irq_early, cyc;
    n = ratio(c, p);
    @(negedge clk);
    start = 1'b1; chan = 3'(ch); cks = c; pre = 2'(p);
    @(negedge clk);
    start = 1'b0;
    check(done == 0, {tag, " R6 done cleared by start"}, done, 0);
    busy_n = 0; samp_n = 0; samp_bad = 0; first_trial = -1; irq_early = 0; cyc = 0;
    while (busy && cyc < 5000) begin
      start = 1'b0;
      busy_n++;
      if (sample) begin
        samp_n++;
        if (dac != 0) samp_bad++;
      end else if (first_trial < 0) begin
        first_trial = dac;
      end
      if (irq) irq_early++;
      cyc++;
      if (cyc == poke_at && poke_mode == 1) begin
        start = 1'b1; chan = 3'd4;
      end
      if (cyc == poke_at && poke_mode == 2) begin
        cks = ~c; pre = (p == 3) ? 2'd0 : 2'd3;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(busy_n == 160 * n, {tag, " R2 conversion length"}, busy_n, 160 * n);
    check(samp_n == 12 * n, {tag, " R4 sampling window"}, samp_n, 12 * n);
    check(samp_bad == 0, {tag, " R4 dac zero while sampling"}, samp_bad, 0);
    check(first_trial == 8'h80, {tag, " R10 first trial code"}, first_trial, 8'h80);
    check(chan_sel == 3'(ch), {tag, " R4 channel select held"}, chan_sel, ch);
    check(irq_early == 0 && irq == 1 && done == 1, {tag, " R6 completion flags"},
          {irq_early[1:0], irq, done}, 3);
    check(32'(result) == vin[ch], {tag, " R5 result"}, result, vin[ch]);
    @(negedge clk);
    check(irq == 0 && done == 1, {tag, " R6 irq one cycle, done sticky"}, {irq, done}, 1);
  endtask

  task automatic t_bad_channel();
    logic [7:0] r0;
    logic [2:0] s0;
    logic d0;
    int seen;
    r0 = result; s0 = chan_sel; d0 = done; seen = 0;
    @(negedge clk);
    start = 1'b1; chan = 3'd6; cks = 1'b1; pre = 2'd0;
    @(negedge clk);
    start = 1'b0;
    repeat (20) begin
      if (busy) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R8 channel 6 start ignored", seen, 0);
    check(result == r0 && done == d0 && chan_sel == s0, "R8 state unchanged", result, r0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    run_conv("R2 cks0 pre00", 2, 1'b0, 0, 0, 0);
    run_conv("R2 cks0 pre01", 1, 1'b0, 1, 0, 0);
    run_conv("R2 cks0 pre11", 0, 1'b0, 3, 0, 0);
    run_conv("R2 cks1 pre00", 3, 1'b1, 0, 0, 0);
    run_conv("R2 cks1 pre01", 4, 1'b1, 1, 0, 0);
    run_conv("R2 cks1 pre11", 5, 1'b1, 3, 0, 0);
    run_conv("R3 cks0 pre10", 2, 1'b0, 2, 0, 0);
    run_conv("R3 cks1 pre10", 1, 1'b1, 2, 0, 0);
    run_conv("R7 start while busy", 2, 1'b1, 1, 100, 1);
    run_conv("R9 settings change", 3, 1'b1, 0, 30, 2);
    t_bad_channel();
    summary();
  end
endmodule